// File: doc/BRIEF.md
# Banked wide-to-narrow memory bridge

This block connects a 32-bit processor I/O port to the user port of a DRAM controller whose read and write data paths are 256 bits wide. Each 256-bit line holds eight 32-bit lanes. A processor read fetches the whole line and hands back the addressed lane. A processor write is a read-modify-write: the bridge fetches the line, overwrites one lane and writes the full line back.

The processor sees only a 1 GB byte window, which is 30 address bits. A small page register, loaded by software through its own strobe, supplies three more address bits above the window. Software can therefore reach an 8 GB memory by switching pages. The bridge serves one transaction at a time and holds every memory command stable until the controller takes it.

Top module: `wide_narrow_bridge`

## Requirements
- R1: After reset, `cpu_ack` and `mem_cmd_valid` are low and `page_o` is 0.
- R2: Every memory command carries line address `{page, cpu_addr[29:5]}`, where `page` is the page value sampled when the strobe was accepted.
- R3: A read (`cpu_we`=0) issues exactly one line read and no write. `cpu_ack` rises in the cycle after `mem_rvalid` is sampled. `cpu_rdata` then holds lane `cpu_addr[4:2]` of the returned line, where lane k is bits [32k+31:32k].
- R4: A write (`cpu_we`=1) issues one line read and then one line write. The written line equals the read line with lane `cpu_addr[4:2]` replaced by `cpu_wdata`. All other lanes are unchanged.
- R5: For a write, `cpu_ack` rises in the cycle after the controller accepts the line write (`mem_cmd_valid` and `mem_cmd_ready` both high). It never rises earlier.
- R6: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command stays valid and its address and direction stay unchanged.
- R7: A strobe that arrives while a transaction is in progress is ignored. It starts no command, either during the transaction or after it.
- R8: `page_o` loads `page_wdata` when `page_we` is high. A page change applies only to transactions accepted after the load cycle. A strobe in the same cycle as the load uses the old page.
- R9: `cpu_ack` is a single-cycle pulse, and byte-address bits [1:0] have no effect on any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stb | input | 1 | Processor access strobe, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 30 | Processor byte address within the window |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read lane returned to the processor |
| cpu_ack | output | 1 | Access complete, one-cycle pulse |
| page_we | input | 1 | Page register load strobe |
| page_wdata | input | 3 | New page value |
| page_o | output | 3 | Current page value |
| mem_cmd_valid | output | 1 | Memory command request |
| mem_cmd_ready | input | 1 | Controller accepts the command |
| mem_cmd_write | output | 1 | 1 = line write, 0 = line read |
| mem_cmd_addr | output | 28 | 32-byte line address |
| mem_wdata | output | 256 | Line write data |
| mem_rdata | input | 256 | Line read data |
| mem_rvalid | input | 1 | Read data valid, one cycle |

## Verification
The bench runs random reads and writes over a small set of line addresses so that reads land on lanes written earlier. This separates correct lane selection and merging from plain pass-through of the memory image. Random page switches, random byte-offset bits and the lowest and highest line addresses test the address concatenation. Directed cases cover a page load coinciding with a strobe and a second strobe arriving mid-transaction, so that the sampling point of the page and the rejection of extra strobes can be seen apart from normal traffic. The memory model varies its acceptance and read latencies, which exposes any acknowledge that arrives before the handshake it depends on.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_ACK     = 3'd4
  } bridge_state_e;

endpackage

// File: rtl/bridge_page_reg.sv
module bridge_page_reg #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] d_i,
  output logic [PAGE_W-1:0] q_o
);

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (ld_i) page_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign q_o = page_q;

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(q_o)); // R8

endmodule

// File: rtl/bridge_lane_mux.sv
module bridge_lane_mux #(
  parameter int CPU_DW  = 32,
  parameter int LINE_DW = 256,
  localparam int LANES  = LINE_DW / CPU_DW,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LINE_DW-1:0] line_i,
  input  logic [LANE_W-1:0]  lane_i,
  input  logic [CPU_DW-1:0]  wdata_i,
  output logic [CPU_DW-1:0]  lane_o,
  output logic [LINE_DW-1:0] merged_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged_o[g*CPU_DW +: CPU_DW] =
      (lane_i == LANE_W'(g)) ? wdata_i : line_i[g*CPU_DW +: CPU_DW];
  end

  always_comb begin
    lane_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_i == LANE_W'(i)) lane_o = line_i[i*CPU_DW +: CPU_DW];
    end
  end

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int CPU_DW   = 32,
  parameter int LINE_DW  = 256,
  parameter int PAGE_W   = 3,
  parameter int MEM_AW   = 28,
  parameter int LANE_W   = 3,
  parameter int WLINE_AW = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_stb,
  input  logic                cpu_we,
  input  logic [WLINE_AW-1:0] cpu_line,
  input  logic [LANE_W-1:0]   cpu_lane,
  input  logic [CPU_DW-1:0]   cpu_wdata,
  input  logic [PAGE_W-1:0]   page_i,
  output logic [CPU_DW-1:0]   cpu_rdata,
  output logic                cpu_ack,
  output logic                mem_cmd_valid,
  input  logic                mem_cmd_ready,
  output logic                mem_cmd_write,
  output logic [MEM_AW-1:0]   mem_cmd_addr,
  output logic [LINE_DW-1:0]  mem_wdata,
  input  logic                mem_rvalid,
  output logic [LANE_W-1:0]   lane_sel_o,
  output logic [CPU_DW-1:0]   wdata_o,
  input  logic [CPU_DW-1:0]   lane_i,
  input  logic [LINE_DW-1:0]  merged_i
);

  bridge_state_e state_q, state_d;

  logic                accept;
  logic                rd_done;
  logic                we_q;
  logic [MEM_AW-1:0]   addr_q;
  logic [LANE_W-1:0]   lane_q;
  logic [CPU_DW-1:0]   wdata_q;
  logic [LINE_DW-1:0]  line_q;
  logic [CPU_DW-1:0]   rdata_q;

  assign accept  = (state_q == ST_IDLE) && cpu_stb;
  assign rd_done = (state_q == ST_RD_WAIT) && mem_rvalid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cpu_stb)       state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_cmd_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid)    state_d = we_q ? ST_WR_REQ : ST_ACK;
      ST_WR_REQ:  if (mem_cmd_ready) state_d = ST_ACK;
      ST_ACK:                        state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      lane_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= cpu_we;
      addr_q  <= {page_i, cpu_line};
      lane_q  <= cpu_lane;
      wdata_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               line_q <= '0;
    else if (rd_done && we_q) line_q <= merged_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (rd_done && !we_q) rdata_q <= lane_i;
  end

  assign lane_sel_o    = lane_q;
  assign wdata_o       = wdata_q;
  assign mem_cmd_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_cmd_write = (state_q == ST_WR_REQ);
  assign mem_cmd_addr  = addr_q;
  assign mem_wdata     = line_q;
  assign cpu_rdata     = rdata_q;
  assign cpu_ack       = (state_q == ST_ACK);

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write))); // R6
  AST_WR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_write && mem_cmd_ready) |=> cpu_ack); // R5
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !mem_cmd_valid); // R7
  AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_cmd_valid && !mem_cmd_write &&
                mem_cmd_addr == {$past(page_i), $past(cpu_line)})); // R2

endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge #(
  parameter int CPU_DW  = 32,
  parameter int LINE_DW = 256,
  parameter int WIN_AW  = 30,
  parameter int PAGE_W  = 3,
  localparam int LANES    = LINE_DW / CPU_DW,
  localparam int LANE_W   = $clog2(LANES),
  localparam int BYTE_OFS = $clog2(CPU_DW / 8),
  localparam int LINE_OFS = BYTE_OFS + LANE_W,
  localparam int WLINE_AW = WIN_AW - LINE_OFS,
  localparam int MEM_AW   = PAGE_W + WLINE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_stb,
  input  logic               cpu_we,
  input  logic [WIN_AW-1:0]  cpu_addr,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  output logic [CPU_DW-1:0]  cpu_rdata,
  output logic               cpu_ack,
  input  logic               page_we,
  input  logic [PAGE_W-1:0]  page_wdata,
  output logic [PAGE_W-1:0]  page_o,
  output logic               mem_cmd_valid,
  input  logic               mem_cmd_ready,
  output logic               mem_cmd_write,
  output logic [MEM_AW-1:0]  mem_cmd_addr,
  output logic [LINE_DW-1:0] mem_wdata,
  input  logic [LINE_DW-1:0] mem_rdata,
  input  logic               mem_rvalid
);

  logic [LANE_W-1:0]  lane_sel;
  logic [CPU_DW-1:0]  wdata_held;
  logic [CPU_DW-1:0]  lane_pick;
  logic [LINE_DW-1:0] line_merged;
  logic               unused_byte_bits;

  assign unused_byte_bits = ^cpu_addr[BYTE_OFS-1:0];

  bridge_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (page_we),
    .d_i   (page_wdata),
    .q_o   (page_o)
  );

  bridge_lane_mux #(.CPU_DW(CPU_DW), .LINE_DW(LINE_DW)) u_mux (
    .line_i   (mem_rdata),
    .lane_i   (lane_sel),
    .wdata_i  (wdata_held),
    .lane_o   (lane_pick),
    .merged_o (line_merged)
  );

  bridge_ctrl #(
    .CPU_DW   (CPU_DW),
    .LINE_DW  (LINE_DW),
    .PAGE_W   (PAGE_W),
    .MEM_AW   (MEM_AW),
    .LANE_W   (LANE_W),
    .WLINE_AW (WLINE_AW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_stb       (cpu_stb),
    .cpu_we        (cpu_we),
    .cpu_line      (cpu_addr[WIN_AW-1:LINE_OFS]),
    .cpu_lane      (cpu_addr[LINE_OFS-1:BYTE_OFS]),
    .cpu_wdata     (cpu_wdata),
    .page_i        (page_o),
    .cpu_rdata     (cpu_rdata),
    .cpu_ack       (cpu_ack),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_write (mem_cmd_write),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_wdata     (mem_wdata),
    .mem_rvalid    (mem_rvalid),
    .lane_sel_o    (lane_sel),
    .wdata_o       (wdata_held),
    .lane_i        (lane_pick),
    .merged_i      (line_merged)
  );

endmodule

// File: tb/sim_wide_narrow_bridge.sv
`timescale 1ns/1ps
module sim_wide_narrow_bridge;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_stb = 1'b0;
  logic         cpu_we = 1'b0;
  logic [29:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ack;
  logic         page_we = 1'b0;
  logic [2:0]   page_wdata = '0;
  logic [2:0]   page_o;
  logic         mem_cmd_valid;
  logic         mem_cmd_ready = 1'b0;
  logic         mem_cmd_write;
  logic [27:0]  mem_cmd_addr;
  logic [255:0] mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic         mem_rvalid = 1'b0;

  always #5 clk = ~clk;

  wide_narrow_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_stb(cpu_stb), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .page_we(page_we), .page_wdata(page_wdata), .page_o(page_o),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0]  refw [logic [30:0]];
  logic [255:0] mem  [logic [27:0]];

  function automatic logic [31:0] dflt(input logic [27:0] ln, input int lane);
    return ({ln, 4'h0} + 32'(lane)) ^ 32'h5A3C_0000;
  endfunction

  function automatic logic [31:0] ref_word(input logic [27:0] ln, input int lane);
    logic [30:0] k = {ln, 3'(lane)};
    if (refw.exists(k)) return refw[k];
    return dflt(ln, lane);
  endfunction

  function automatic logic [255:0] ref_line(input logic [27:0] ln);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = ref_word(ln, i);
    return r;
  endfunction

  function automatic logic [255:0] mem_line(input logic [27:0] ln);
    logic [255:0] r;
    if (mem.exists(ln)) return mem[ln];
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = dflt(ln, i);
    return r;
  endfunction

  // ---------------- memory model ----------------
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          rv_cyc = 0;
  int          wr_cyc = 0;
  logic [27:0] exp_line = '0;
  logic [27:0] m_a;
  logic        m_w;
  logic [255:0] m_wd;
  int          m_d;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_cmd_valid) begin
        m_a = mem_cmd_addr;
        m_w = mem_cmd_write;
        m_d = $urandom_range(0, 3);
        for (int i = 0; i < m_d; i++) begin
          @(negedge clk);
          chk(mem_cmd_valid && mem_cmd_addr == m_a && mem_cmd_write == m_w,
              "R6 command held", {mem_cmd_valid, mem_cmd_write, mem_cmd_addr},
              {1'b1, m_w, m_a});
        end
        chk(mem_cmd_addr == exp_line, "R2 line address", mem_cmd_addr, exp_line);
        m_wd = mem_wdata;
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        if (m_w) begin
          mem[m_a] = m_wd;
          wr_cnt++;
          wr_cyc = cyc;
        end else begin
          rd_cnt++;
          m_d = $urandom_range(0, 3);
          for (int i = 0; i < m_d; i++) @(negedge clk);
          mem_rdata  = mem_line(m_a);
          mem_rvalid = 1'b1;
          @(negedge clk);
          mem_rvalid = 1'b0;
          rv_cyc = cyc;
          mem_rdata = {8{$urandom()}};
        end
      end
    end
  end

  // ---------------- processor driver ----------------
  logic [2:0] cur_page = '0;

  task automatic set_page(input logic [2:0] p);
    @(negedge clk);
    page_we = 1'b1;
    page_wdata = p;
    @(negedge clk);
    page_we = 1'b0;
    cur_page = p;
    chk(page_o == p, "R8 page load", page_o, p);
  endtask

  task automatic access(input bit we, input logic [29:0] a, input logic [31:0] d,
                        input bit pg_same, input logic [2:0] newpg, input bit intrude);
    int rd0, wr0, k, ack_c;
    int lane;
    lane = int'(a[4:2]);
    @(negedge clk);
    cpu_stb = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (pg_same) begin page_we = 1'b1; page_wdata = newpg; end
    exp_line = {cur_page, a[29:5]};
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    page_we = 1'b0;
    if (pg_same) cur_page = newpg;
    if (intrude) begin
      cpu_we = 1'b1; cpu_addr = a ^ 30'h2000_0FE0; cpu_wdata = ~d;
      @(negedge clk);
    end
    cpu_stb = 1'b0;
    k = 0;
    while (!cpu_ack && k < 60) begin @(negedge clk); k++; end
    #1;
    ack_c = cyc;
    chk(cpu_ack == 1'b1, "R3 ack arrives", cpu_ack, 1);
    chk(rd_cnt - rd0 == 1, "R3 one line read", rd_cnt - rd0, 1);
    chk(wr_cnt - wr0 == (we ? 1 : 0), "R4 line write count", wr_cnt - wr0, we);
    if (we) begin
      refw[{exp_line, 3'(lane)}] = d;
      chk(ack_c == wr_cyc, "R5 ack after write accept", ack_c, wr_cyc);
      chk(mem_line(exp_line) == ref_line(exp_line), "R4 merged line",
          mem_line(exp_line), ref_line(exp_line));
    end else begin
      chk(ack_c == rv_cyc, "R3 ack after rvalid", ack_c, rv_cyc);
      chk(cpu_rdata == ref_word(exp_line, lane), "R3 read lane",
          cpu_rdata, ref_word(exp_line, lane));
    end
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R9 ack single pulse", cpu_ack, 0);
    @(negedge clk);
    chk(mem_cmd_valid == 1'b0, "R7 no command after ack", mem_cmd_valid, 0);
  endtask

  logic [29:0] pool [4];

  initial begin
    void'($urandom(32'd20240611));
    pool[0] = 30'h0000_0000;
    pool[1] = 30'h3FFF_FFE0;
    pool[2] = 30'h1234_5660;
    pool[3] = 30'h0ABC_DE00;

    #1;
    chk(cpu_ack == 0 && mem_cmd_valid == 0 && page_o == 0, "R1 reset state",
        {cpu_ack, mem_cmd_valid, page_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ack == 0 && mem_cmd_valid == 0 && page_o == 0, "R1 after release",
        {cpu_ack, mem_cmd_valid, page_o}, 0);

    // directed: lowest address, lane 0 read, page 0
    access(0, 30'h0, 0, 0, 0, 0);
    // directed: lane 7 write then read back, byte bits set (R9)
    access(1, 30'h0000_001F, 32'hDEAD_BEEF, 0, 0, 0);
    access(0, 30'h0000_001C, 0, 0, 0, 0);
    // directed: highest page and line (R2)
    set_page(3'd7);
    access(1, 30'h3FFF_FFFF, 32'h0BAD_F00D, 0, 0, 0);
    access(0, 30'h3FFF_FFFC, 0, 0, 0, 0);
    // directed: page load coinciding with strobe uses the old page (R8)
    access(0, 30'h3FFF_FFFC, 0, 1, 3'd2, 0);
    chk(page_o == 3'd2, "R8 page after same-cycle load", page_o, 2);
    access(0, 30'h3FFF_FFFC, 0, 0, 0, 0);
    // directed: intruding strobe mid-transaction (R7)
    access(1, 30'h1234_5668, 32'h1111_2222, 0, 0, 1);
    access(0, 30'h1234_5668, 0, 0, 0, 1);

    for (int n = 0; n < 300; n++) begin
      logic [29:0] a;
      a = pool[$urandom_range(0, 3)] | 30'($urandom_range(0, 31));
      if ($urandom_range(0, 9) == 0) set_page(3'($urandom_range(0, 7)));
      access($urandom_range(0, 1) == 1, a, $urandom(),
             $urandom_range(0, 15) == 0, 3'($urandom_range(0, 7)),
             $urandom_range(0, 7) == 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule